// File: doc/BRIEF.md
# Fragmenting Response Packet Transmitter

This block turns queued commands into reply frames on a byte-wide transmit stream. When it is idle and the command queue holds an entry, it takes one command. It then sends a ten-byte header that echoes the command. If the command is a read with a non-zero byte count, local memory bytes follow the header. A 16-bit ones'-complement checksum closes each frame.

A read that asks for more than `MAX_PAY` bytes is split into several frames. Between frames the echoed address and remaining count move forward, and an offset field tells the receiver where each piece belongs. Memory has a fixed read latency of `RD_LAT` cycles. Reads are issued early enough that a frame, once started, streams without gaps.

Top module: `frag_tx`

## Requirements
- R1: After reset, `tx_valid_o`, `mem_rd_en_o` and `cmd_pop_o` are low while the queue is empty.
- R2: `cmd_pop_o` pulses for one cycle only when the block is idle and `cmd_empty_i` is low. Every queued command is taken exactly once. The command word is opcode in bits 39:32, address in bits 31:16 and byte count in bits 15:0.
- R3: Each frame starts with ten header bytes, in this order:
  - byte 0 is flags: bit 0 marks the last fragment, bit 1 means payload present, and the other bits are zero;
  - bytes 1–2 are the byte offset of this fragment, high byte first;
  - bytes 3–4 are the payload length of this fragment;
  - byte 5 is the opcode;
  - bytes 6–7 are the current address;
  - bytes 8–9 are the remaining count.
- R4: A command whose opcode bit 0 is clear produces one 12-byte frame: the header plus the checksum. Its flags byte is 0x01, and it reads no memory.
- R5: Payload byte i of a fragment is the memory byte at (fragment address + i) mod 65536.
- R6: A fragment's payload length is min(remaining, `MAX_PAY`). The next fragment's address and offset grow by that length and its remaining count shrinks by it. Only the final fragment has the last flag set.
- R7: The final two bytes are the checksum, high byte first, with `tx_last_o` on the low byte. It is formed as follows: take big-endian 16-bit words over all earlier bytes of the frame, padding an odd last byte with a zero low byte; add them with end-around carry; complement the sum; send 0x0000 as 0xFFFF.
- R8: `tx_valid_o` stays high from a frame's first byte to its last. At least one idle cycle separates frames.
- R9: Each fragment issues exactly as many memory reads as its payload length.
- R10: A read command with a byte count of zero is handled as a command without data: one 12-byte frame with flags 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmd_empty_i | input | 1 | Command queue empty |
| cmd_data_i | input | 40 | Head-of-queue command word |
| cmd_pop_o | output | 1 | Take the head command |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data, `RD_LAT` cycles after the request |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Last byte of a frame |

## Verification
The hardest conditions to reach are a fragment boundary that lands exactly on `MAX_PAY`, where the count runs out together with the size limit, and a fragment whose address range wraps past 0xFFFF. The bench builds the maximum payload small so these points come up quickly. It drives counts of exactly `MAX_PAY`, `MAX_PAY`+1 and a wrapping start address. It also queues commands back to back, which exercises the return from the end of one frame straight into the next command. Random commands with odd and even lengths cover the checksum's padding of an odd final byte.

// File: rtl/frag_tx_pkg.sv
package frag_tx_pkg;
    localparam int ADDR_W    = 16;
    localparam int CNT_W     = 16;
    localparam int OP_W      = 8;
    localparam int CMD_W     = OP_W + ADDR_W + CNT_W;
    localparam int HDR_BYTES = 10;
    localparam int RD_BIT    = 0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND, ST_CKHI, ST_CKLO, ST_ENDP
    } tx_st_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } cmd_t;
endpackage

// File: rtl/frag_csum.sv
module frag_csum (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        clr_i,
    input  logic        en_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] csum_o
);
    typedef struct packed {
        logic [15:0] sum;
        logic [7:0]  hi;
        logic        odd;
    } acc_t;

    acc_t acc_d, acc_q;

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    always_comb begin
        acc_d = acc_q;
        if (clr_i) begin
            acc_d = '0;
        end else if (en_i) begin
            if (!acc_q.odd) begin
                acc_d.hi  = byte_i;
                acc_d.odd = 1'b1;
            end else begin
                acc_d.sum = oc_add(acc_q.sum, {acc_q.hi, byte_i});
                acc_d.odd = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) acc_q <= '0;
        else       acc_q <= acc_d;
    end

    logic [15:0] total, inv;
    always_comb begin
        total  = acc_q.odd ? oc_add(acc_q.sum, {acc_q.hi, 8'h00}) : acc_q.sum;
        inv    = ~total;
        csum_o = (inv == 16'h0000) ? 16'hFFFF : inv;
    end

    // R7
    clr_en_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |-> !en_i);
endmodule

// File: rtl/frag_hdr.sv
module frag_hdr (
    input  logic [3:0]  idx_i,
    input  logic        last_i,
    input  logic        has_data_i,
    input  logic [15:0] off_i,
    input  logic [15:0] len_i,
    input  logic [7:0]  op_i,
    input  logic [15:0] addr_i,
    input  logic [15:0] rem_i,
    output logic [7:0]  byte_o
);
    always_comb begin
        case (idx_i)
            4'd0:    byte_o = {6'd0, has_data_i, last_i};
            4'd1:    byte_o = off_i[15:8];
            4'd2:    byte_o = off_i[7:0];
            4'd3:    byte_o = len_i[15:8];
            4'd4:    byte_o = len_i[7:0];
            4'd5:    byte_o = op_i;
            4'd6:    byte_o = addr_i[15:8];
            4'd7:    byte_o = addr_i[7:0];
            4'd8:    byte_o = rem_i[15:8];
            4'd9:    byte_o = rem_i[7:0];
            default: byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/frag_tx.sv
module frag_tx
    import frag_tx_pkg::*;
#(
    parameter int MAX_PAY = 1472,
    parameter int RD_LAT  = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cmd_empty_i,
    input  logic [CMD_W-1:0]  cmd_data_i,
    output logic              cmd_pop_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_last_o
);
    localparam logic [CNT_W-1:0] MAX_L = CNT_W'(MAX_PAY);
    localparam logic [16:0]      HDR_L = 17'(HDR_BYTES);
    localparam logic [16:0]      LAT_L = 17'(RD_LAT);

    if (RD_LAT < 1 || RD_LAT > HDR_BYTES) begin : g_lat_bad
        $error("RD_LAT must lie between 1 and the header length");
    end

    typedef struct packed {
        tx_st_e            st;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
        logic [CNT_W-1:0]  off;
        logic [15:0]       pos;
        logic              tv;
        logic [7:0]        td;
        logic              tl;
    } reg_t;

    reg_t r_d, r_q;
    cmd_t cmd;
    assign cmd = cmd_t'(cmd_data_i);

    logic        has_data, is_last, more;
    logic [15:0] flen, last_pos;
    logic [16:0] ahead, rd_off;
    logic [7:0]  hdr_byte;
    logic [15:0] csum;
    logic        cs_en, cs_clr, pop;

    always_comb begin
        has_data = r_q.op[RD_BIT] && (r_q.rem != '0);
        flen     = !has_data ? 16'd0 : ((r_q.rem > MAX_L) ? MAX_L : r_q.rem);
        is_last  = !has_data || (r_q.rem <= MAX_L);
        more     = !is_last;
        last_pos = 16'(HDR_BYTES) + flen - 16'd1;
        ahead    = {1'b0, r_q.pos} + LAT_L;
        rd_off   = ahead - HDR_L;
    end

    frag_hdr u_hdr (
        .idx_i      (r_q.pos[3:0]),
        .last_i     (is_last),
        .has_data_i (has_data),
        .off_i      (r_q.off),
        .len_i      (flen),
        .op_i       (r_q.op),
        .addr_i     (r_q.addr),
        .rem_i      (r_q.rem),
        .byte_o     (hdr_byte)
    );

    // Fetch runs RD_LAT bytes ahead of the byte being loaded.
    assign mem_rd_en_o = (r_q.st == ST_SEND) && (ahead >= HDR_L) && (rd_off < {1'b0, flen});
    assign mem_addr_o  = r_q.addr + rd_off[15:0];

    always_comb begin
        r_d    = r_q;
        r_d.tv = 1'b0;
        r_d.tl = 1'b0;
        pop    = 1'b0;
        cs_en  = 1'b0;
        cs_clr = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                cs_clr = 1'b1;
                if (!cmd_empty_i) begin
                    pop      = 1'b1;
                    r_d.op   = cmd.op;
                    r_d.addr = cmd.addr;
                    r_d.rem  = cmd.cnt;
                    r_d.off  = '0;
                    r_d.pos  = '0;
                    r_d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                r_d.tv  = 1'b1;
                r_d.td  = (r_q.pos < 16'(HDR_BYTES)) ? hdr_byte : mem_rdata_i;
                cs_en   = 1'b1;
                r_d.pos = r_q.pos + 16'd1;
                if (r_q.pos == last_pos) r_d.st = ST_CKHI;
            end
            ST_CKHI: begin
                r_d.tv = 1'b1;
                r_d.td = csum[15:8];
                r_d.st = ST_CKLO;
            end
            ST_CKLO: begin
                r_d.tv = 1'b1;
                r_d.td = csum[7:0];
                r_d.tl = 1'b1;
                r_d.st = ST_ENDP;
            end
            ST_ENDP: begin
                cs_clr = 1'b1;
                if (more) begin
                    r_d.addr = r_q.addr + flen;
                    r_d.rem  = r_q.rem - flen;
                    r_d.off  = r_q.off + flen;
                    r_d.pos  = '0;
                    r_d.st   = ST_SEND;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    frag_csum u_csum (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (cs_clr),
        .en_i   (cs_en),
        .byte_i (r_d.td),
        .csum_o (csum)
    );

    assign cmd_pop_o  = pop;
    assign tx_valid_o = r_q.tv;
    assign tx_data_o  = r_q.td;
    assign tx_last_o  = r_q.tl;

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (!tx_valid_o && !mem_rd_en_o));
    // R2
    pop_avail_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_pop_o |-> !cmd_empty_i);
    // R7
    last_valid_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_last_o |-> tx_valid_o);
    // R8
    no_bubble_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tx_valid_o && !tx_last_o) |=> tx_valid_o);
    // R8
    frame_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_last_o |=> !tx_valid_o);
    // R9
    rd_no_pop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_rd_en_o |-> !cmd_pop_o);
endmodule

// File: tb/frag_tx_bench.sv
module frag_tx_bench;
    localparam int MAXP = 64;
    localparam int LAT  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_empty, cmd_pop, mem_rd_en, tx_valid, tx_last;
    logic [39:0] cmd_data;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata, tx_data;

    always #10 clk = ~clk;

    frag_tx #(.MAX_PAY(MAXP), .RD_LAT(LAT)) u_frag_tx (
        .clk_i(clk), .rst_i(rst),
        .cmd_empty_i(cmd_empty), .cmd_data_i(cmd_data), .cmd_pop_o(cmd_pop),
        .mem_rd_en_o(mem_rd_en), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last)
    );

    function automatic logic [7:0] memb(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // memory model: data RD_LAT cycles after request
    logic [7:0] mp [LAT];
    always @(posedge clk) begin
        mp[0] <= mem_rd_en ? memb(mem_addr) : 8'h00;
        for (int i = 1; i < LAT; i++) mp[i] <= mp[i-1];
    end
    assign mem_rdata = mp[LAT-1];

    // command queue model
    logic [39:0] fq [0:63];
    int wp = 0, rp = 0;
    assign cmd_empty = (wp == rp);
    assign cmd_data  = fq[rp[5:0]];
    always @(posedge clk) if (cmd_pop) rp <= rp + 1;

    // monitor
    logic [7:0] fb [0:255];
    logic [7:0] lastf [0:255];
    int fpos = 0, lastn = 0, frames_rx = 0, pops = 0, pop_bad = 0;
    int reads = 0, bubbles = 0, gap_bad = 0;
    bit in_fr = 0, prev_last = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_pop) pops++;
            if (cmd_pop && cmd_empty) pop_bad++;
            if (mem_rd_en) reads++;
            if (tx_valid) begin
                if (!in_fr) begin
                    fpos = 0;
                    if (prev_last) gap_bad++;
                end
                fb[fpos[7:0]] = tx_data;
                fpos++;
                in_fr = 1;
                if (tx_last) begin
                    for (int i = 0; i < 256; i++) lastf[i] = fb[i];
                    lastn = fpos;
                    in_fr = 0;
                    frames_rx++;
                end
            end else if (in_fr) begin
                bubbles++;
            end
            prev_last = tx_valid && tx_last;
        end
    end

    int tests = 0, fails = 0, pushed = 0, exp_reads = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    logic [7:0] eb [0:255];
    int en = 0;

    function automatic int cks(input int n);
        int unsigned s = 0;
        int unsigned c;
        for (int i = 0; i < n; i += 2) begin
            s += {16'd0, eb[i], ((i + 1 < n) ? eb[i+1] : 8'h00)};
            while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        end
        c = (~s) & 32'hFFFF;
        return (c == 0) ? 32'hFFFF : int'(c);
    endfunction

    task automatic push(input logic [7:0] op, input logic [15:0] a, input logic [15:0] c);
        @(posedge clk); #1;
        fq[wp[5:0]] = {op, a, c};
        wp++;
        pushed++;
    endtask

    task automatic expect_cmd(input logic [7:0] op, input logic [15:0] a0, input logic [15:0] c0, input string tag);
        int rem = int'(c0), off = 0, a = int'(a0), len, c, hbad, pbad, n0;
        bit hd = op[0] && (c0 != 0);
        bit last;
        do begin
            len  = hd ? ((rem > MAXP) ? MAXP : rem) : 0;
            last = !hd || (rem <= MAXP);
            eb[0] = {6'd0, hd, last};
            eb[1] = 8'(off >> 8); eb[2] = 8'(off);
            eb[3] = 8'(len >> 8); eb[4] = 8'(len);
            eb[5] = op;
            eb[6] = 8'(a >> 8);   eb[7] = 8'(a);
            eb[8] = 8'(rem >> 8); eb[9] = 8'(rem);
            for (int i = 0; i < len; i++) eb[10+i] = memb(16'(a + i));
            en = 10 + len;
            c = cks(en);
            eb[en] = 8'(c >> 8); eb[en+1] = 8'(c);
            en += 2;
            exp_reads += len;
            n0 = frames_rx;
            while (frames_rx == n0) @(negedge clk);
            chk(lastn == en, "R6", {tag, " frame length"}, lastn, en);
            if (lastn == en) begin
                hbad = -1; pbad = -1;
                for (int i = 0; i < 10; i++) if (hbad < 0 && lastf[i] != eb[i]) hbad = i;
                for (int i = 10; i < en - 2; i++) if (pbad < 0 && lastf[i] != eb[i]) pbad = i;
                chk(hbad < 0, "R3", {tag, " header byte"}, (hbad < 0) ? 0 : int'(lastf[hbad]),
                    (hbad < 0) ? 0 : int'(eb[hbad]));
                chk(pbad < 0, "R5", {tag, " payload byte"}, (pbad < 0) ? 0 : int'(lastf[pbad]),
                    (pbad < 0) ? 0 : int'(eb[pbad]));
                chk({lastf[en-2], lastf[en-1]} == {eb[en-2], eb[en-1]}, "R7", {tag, " checksum"},
                    int'({lastf[en-2], lastf[en-1]}), c);
            end
            if (!last) begin
                a = (a + len) & 16'hFFFF; rem -= len; off += len;
            end
        end while (!last);
    endtask

    task automatic run(input logic [7:0] op, input logic [15:0] a, input logic [15:0] c, input string tag);
        push(op, a, c);
        expect_cmd(op, a, c, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd1234);
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!tx_valid && !mem_rd_en && !cmd_pop, "R1", "outputs idle after reset",
            int'({tx_valid, mem_rd_en, cmd_pop}), 0);

        run(8'h02, 16'h0100, 16'd100, "R4 no-data");
        chk(lastn == 12 && lastf[0] == 8'h01, "R4", "no-data frame flags", int'(lastf[0]), 1);
        run(8'h01, 16'h2000, 16'd0, "R10 zero count");
        chk(lastn == 12 && lastf[0] == 8'h01, "R10", "zero-count flags", int'(lastf[0]), 1);
        run(8'h01, 16'h1234, 16'd1, "R7 odd length");
        run(8'h03, 16'h4000, 16'(MAXP), "R6 exact max");
        chk(frames_rx == 4 && lastf[0] == 8'h03, "R6", "exact max single last frame", int'(lastf[0]), 3);
        run(8'h01, 16'h5000, 16'(MAXP + 1), "R6 max plus one");
        run(8'h11, 16'hFFF0, 16'd150, "R5 address wrap");

        // back to back queued commands
        push(8'h01, 16'h0A00, 16'd70);
        push(8'h04, 16'h0B00, 16'd5);
        push(8'h01, 16'h0C01, 16'd33);
        expect_cmd(8'h01, 16'h0A00, 16'd70, "R2 queued a");
        expect_cmd(8'h04, 16'h0B00, 16'd5, "R2 queued b");
        expect_cmd(8'h01, 16'h0C01, 16'd33, "R2 queued c");

        for (int k = 0; k < 30; k++) begin
            logic [7:0]  op;
            logic [15:0] a, c;
            op = 8'($urandom);
            a  = 16'($urandom);
            c  = 16'($urandom_range(0, 3 * MAXP + 7));
            run(op, a, c, "random");
        end

        repeat (5) @(negedge clk);
        chk(pops == pushed && pop_bad == 0, "R2", "pops versus commands", pops, pushed);
        chk(reads == exp_reads, "R9", "memory reads", reads, exp_reads);
        chk(bubbles == 0, "R8", "bubbles inside frames", bubbles, 0);
        chk(gap_bad == 0, "R8", "frames without idle gap", gap_bad, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule